// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Hi/Lo Result Pair

This unit performs integer multiplication and division for a 32-bit RISC core and owns the two result registers, Hi and Lo, that hold its outputs. A single-cycle start strobe supplies a two-bit operation code and two operands. The unit then runs one iteration per clock for a fixed number of cycles. A busy flag stays raised during that time. When the work ends, the result lands in Hi and Lo together.

A multiply leaves the double-width product split across the pair, with the upper half in Hi and the lower half in Lo. A divide leaves the quotient in Lo and the remainder in Hi. Each operation has a two's-complement variant and an unsigned variant. Signed work runs on operand magnitudes, and the signs are applied when the result is written. Move-from instructions read Hi and Lo directly from the two output ports.

A division by zero raises no error. It produces a defined result, and pipeline interlocking is left to the core, which watches the busy output.

Top module: `muldiv_unit`

## Requirements
- R1: `op_i` encodes the operation: 2'b00 signed multiply, 2'b01 unsigned multiply, 2'b10 signed divide, 2'b11 unsigned divide.
- R2: A start strobe sampled while idle is accepted, and `busy_o` is high in the following cycle.
- R3: After acceptance, `busy_o` stays high for exactly WIDTH (default 32) cycles. The new Hi and Lo values appear in the first cycle in which `busy_o` is low again.
- R4: Unsigned multiply sets {Hi, Lo} to the full 64-bit unsigned product.
- R5: Signed multiply sets {Hi, Lo} to the full 64-bit two's-complement product.
- R6: Unsigned divide sets Lo to the quotient and Hi to the remainder.
- R7: Signed divide truncates the quotient toward zero and gives the remainder the dividend's sign. The most negative dividend divided by -1 gives a quotient of 0x80000000 and a remainder of 0.
- R8: A start strobe while `busy_o` is high is ignored. The operation in flight finishes with its original operands and operation.
- R9: Hi and Lo keep their values at all times except the cycle in which an operation completes.
- R10: A zero divisor, signed or unsigned, gives Lo = all ones and Hi = the dividend unchanged.
- R11: After synchronous reset, `busy_o`, `hi_o` and `lo_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| op_i | input | 2 | Operation code (see R1) |
| a_i | input | WIDTH | First operand: multiplicand or dividend |
| b_i | input | WIDTH | Second operand: multiplier or divisor |
| busy_o | output | 1 | High while an operation is iterating |
| hi_o | output | WIDTH | Hi register: upper product half or remainder |
| lo_o | output | WIDTH | Lo register: lower product half or quotient |

## Verification
A wrong iteration count or a busy flag that sticks shows at `busy_o` within one operation, in the cycle where the reference expects it to drop. A corrupted partial remainder, a lost carry in the accumulator, or a wrong sign flag stays hidden while the unit is busy. It shows in full on `hi_o` and `lo_o` in the completion cycle, so every operation is compared on the cycle its result lands. A start strobe that leaks through while busy changes the result of the operation in flight. The checks therefore probe starts both in the middle of an operation and on its last busy cycle.

// File: rtl/muldiv_pkg.sv
// Shared operation encoding and helpers for the multiply-divide unit.
// Assumes the two code bits equal the low bits of the core's funct field.
package muldiv_pkg;

    typedef enum logic [1:0] {
        MD_MUL_S = 2'b00,
        MD_MUL_U = 2'b01,
        MD_DIV_S = 2'b10,
        MD_DIV_U = 2'b11
    } md_op_e;

    // True for either divide variant.
    function automatic logic md_is_div(input md_op_e op);
        return op[1];
    endfunction

    // True for the two's-complement variants.
    function automatic logic md_is_signed(input md_op_e op);
        return ~op[0];
    endfunction

endpackage

// File: rtl/md_seq.sv
// Iteration sequencer: accepts a start while idle, then counts WIDTH
// iteration cycles. Assumes the start strobe is sampled on every edge.
module md_seq #(
    parameter int WIDTH = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic busy_o,
    output logic last_o
);
    localparam int CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    // Accept only while idle; a start during busy is dropped.
    always_comb begin
        accept_o = start_i & ~busy_q;
        last_o   = busy_q & (cnt_q == LAST);
        busy_o   = busy_q;
    end

    // Busy flag and iteration counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
            end
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    busy_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |=> busy_q);

endmodule

// File: rtl/md_prep.sv
// Operand preparation: converts signed operands to magnitudes and
// derives the sign corrections for the final result. Purely combinational.
module md_prep
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  md_op_e           op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] a_mag_o,
    output logic [WIDTH-1:0] b_mag_o,
    output logic             neg_prod_o,
    output logic             neg_quo_o,
    output logic             neg_rem_o
);
    logic a_neg, b_neg, b_zero;

    // Magnitudes and sign flags.
    always_comb begin
        a_neg      = md_is_signed(op_i) & a_i[WIDTH-1];
        b_neg      = md_is_signed(op_i) & b_i[WIDTH-1];
        b_zero     = (b_i == '0);
        a_mag_o    = a_neg ? (~a_i + 1'b1) : a_i;
        b_mag_o    = b_neg ? (~b_i + 1'b1) : b_i;
        neg_prod_o = a_neg ^ b_neg;
        neg_quo_o  = (a_neg ^ b_neg) & ~b_zero;
        neg_rem_o  = a_neg;
    end

endmodule

// File: rtl/md_iter.sv
// Iteration datapath shared by both operations. Multiply runs shift-add
// with the multiplier in the low register; divide runs restoring division
// with the dividend shifting out of the low register. After WIDTH steps the
// upper/lower registers hold {product} or {remainder, quotient}.
module md_iter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             is_div_i,
    input  logic [WIDTH-1:0] a_mag_i,
    input  logic [WIDTH-1:0] b_mag_i,
    output logic [WIDTH-1:0] nxt_up_o,
    output logic [WIDTH-1:0] nxt_lo_o
);
    logic [WIDTH-1:0] up_q, lo_q, opnd_q;
    logic             div_q;
    logic [WIDTH:0]   m_sum;
    logic [WIDTH:0]   d_shift;
    logic [WIDTH+1:0] d_trial;
    logic             d_fit;

    // One shift-add or one restoring step, chosen by the latched operation.
    always_comb begin
        m_sum   = {1'b0, up_q} + (lo_q[0] ? {1'b0, opnd_q} : '0);
        d_shift = {up_q, lo_q[WIDTH-1]};
        d_trial = {1'b0, d_shift} - {2'b00, opnd_q};
        d_fit   = ~d_trial[WIDTH+1];
        if (div_q) begin
            nxt_up_o = d_fit ? d_trial[WIDTH-1:0] : d_shift[WIDTH-1:0];
            nxt_lo_o = {lo_q[WIDTH-2:0], d_fit};
        end else begin
            nxt_up_o = m_sum[WIDTH:1];
            nxt_lo_o = {m_sum[0], lo_q[WIDTH-1:1]};
        end
    end

    // Working registers: loaded on accept, advanced on every busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q   <= '0;
            lo_q   <= '0;
            opnd_q <= '0;
            div_q  <= 1'b0;
        end else if (load_i) begin
            up_q   <= '0;
            lo_q   <= is_div_i ? a_mag_i : b_mag_i;
            opnd_q <= is_div_i ? b_mag_i : a_mag_i;
            div_q  <= is_div_i;
        end else if (step_i) begin
            up_q <= nxt_up_o;
            lo_q <= nxt_lo_o;
        end
    end

endmodule

// File: rtl/md_fix.sv
// Result sign correction: negates the double-width product, or the
// quotient and remainder separately, according to the latched flags.
module md_fix #(
    parameter int WIDTH = 32
) (
    input  logic             is_div_i,
    input  logic             neg_prod_i,
    input  logic             neg_quo_i,
    input  logic             neg_rem_i,
    input  logic [WIDTH-1:0] raw_up_i,
    input  logic [WIDTH-1:0] raw_lo_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] prod;

    // Apply signs to the raw magnitude result.
    always_comb begin
        prod = {raw_up_i, raw_lo_i};
        if (neg_prod_i) begin
            prod = ~prod + 1'b1;
        end
        if (is_div_i) begin
            hi_o = neg_rem_i ? (~raw_up_i + 1'b1) : raw_up_i;
            lo_o = neg_quo_i ? (~raw_lo_i + 1'b1) : raw_lo_i;
        end else begin
            hi_o = prod[PW-1:WIDTH];
            lo_o = prod[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
// Multiply-divide unit top: latches the operation on accept, iterates for
// WIDTH cycles and writes Hi/Lo on the last one. Assumes the core waits on
// busy_o before issuing dependent moves from Hi or Lo.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    md_op_e           op_in;
    md_op_e           op_q;
    logic             accept, last;
    logic [WIDTH-1:0] a_mag, b_mag;
    logic             neg_prod, neg_quo, neg_rem;
    logic             neg_prod_q, neg_quo_q, neg_rem_q;
    logic [WIDTH-1:0] nxt_up, nxt_lo;
    logic [WIDTH-1:0] fix_hi, fix_lo;
    logic [WIDTH-1:0] hi_q, lo_q;

    assign op_in = md_op_e'(op_i);

    md_seq #(.WIDTH(WIDTH)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy_o),
        .last_o   (last)
    );

    md_prep #(.WIDTH(WIDTH)) prep_i (
        .op_i       (op_in),
        .a_i        (a_i),
        .b_i        (b_i),
        .a_mag_o    (a_mag),
        .b_mag_o    (b_mag),
        .neg_prod_o (neg_prod),
        .neg_quo_o  (neg_quo),
        .neg_rem_o  (neg_rem)
    );

    md_iter #(.WIDTH(WIDTH)) iter_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (busy_o),
        .is_div_i (md_is_div(op_in)),
        .a_mag_i  (a_mag),
        .b_mag_i  (b_mag),
        .nxt_up_o (nxt_up),
        .nxt_lo_o (nxt_lo)
    );

    md_fix #(.WIDTH(WIDTH)) fix_i (
        .is_div_i   (md_is_div(op_q)),
        .neg_prod_i (neg_prod_q),
        .neg_quo_i  (neg_quo_q),
        .neg_rem_i  (neg_rem_q),
        .raw_up_i   (nxt_up),
        .raw_lo_i   (nxt_lo),
        .hi_o       (fix_hi),
        .lo_o       (fix_lo)
    );

    // Latch the operation and its sign corrections on accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= MD_MUL_S;
            neg_prod_q <= 1'b0;
            neg_quo_q  <= 1'b0;
            neg_rem_q  <= 1'b0;
        end else if (accept) begin
            op_q       <= op_in;
            neg_prod_q <= neg_prod;
            neg_quo_q  <= neg_quo;
            neg_rem_q  <= neg_rem;
        end
    end

    // Hi/Lo result registers: written only by the final iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (last) begin
            hi_q <= fix_hi;
            lo_q <= fix_lo;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);

    // R8
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i |=> $stable(op_q));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(hi_o) && $stable(lo_o));

endmodule

// File: tb/muldiv_unit_tb_top.sv
// Bench for muldiv_unit: a behavioural reference model updated on each
// rising edge and compared against the ports 5 ns after every edge.
module muldiv_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic        busy;
    logic [31:0] hi, lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state.
    bit          m_busy = 1'b0;
    int          m_left = 0;
    logic [31:0] m_hi = '0, m_lo = '0;
    logic [63:0] m_pend = '0;
    string       cur_tag = "R11";

    always #10 clk = ~clk;

    muldiv_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .op_i    (op),
        .a_i     (a),
        .b_i     (b),
        .busy_o  (busy),
        .hi_o    (hi),
        .lo_o    (lo)
    );

    // Expected {Hi, Lo} from the requirements (R1 encodings).
    function automatic logic [63:0] ref_calc(logic [1:0] o, logic [31:0] x, logic [31:0] y);
        longint sx = longint'($signed(x));
        longint sy = longint'($signed(y));
        longint unsigned ux = {32'h0, x};
        longint unsigned uy = {32'h0, y};
        longint q, r;
        logic [63:0] res;
        if (!o[1]) begin
            res = o[0] ? 64'(ux * uy) : 64'(sx * sy);
        end else if (y == 32'h0) begin
            res = {x, 32'hFFFF_FFFF};
        end else if (o[0]) begin
            res = {32'(ux % uy), 32'(ux / uy)};
        end else begin
            q = sx / sy;
            r = sx % sy;
            res = {32'(r), 32'(q)};
        end
        return res;
    endfunction

    // Reference model step.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0; m_left = 0; m_hi = '0; m_lo = '0;
        end else if (m_busy) begin
            if (m_left == 1) begin
                m_busy = 1'b0;
                m_hi = m_pend[63:32];
                m_lo = m_pend[31:0];
            end
            m_left = m_left - 1;
        end else if (start) begin
            m_busy = 1'b1;
            m_left = 32;
            m_pend = ref_calc(op, a, b);
        end
    end

    // Per-cycle comparison, away from the edge.
    always begin
        @(posedge clk);
        #5;
        if (!done) begin
            checks++;
            if (busy !== m_busy) begin
                errors++;
                $display("FAIL %s busy actual %0b expected %0b", (m_left == 32) ? "R2" : "R3", busy, m_busy);
            end
            checks++;
            if (hi !== m_hi || lo !== m_lo) begin
                errors++;
                $display("FAIL %s hi/lo actual %h_%h expected %h_%h", cur_tag, hi, lo, m_hi, m_lo);
            end
        end
    end

    task automatic pulse(logic [1:0] o, logic [31:0] x, logic [31:0] y);
        @(negedge clk);
        start = 1'b1; op = o; a = x; b = y;
        @(negedge clk);
        start = 1'b0; a = ~x; b = ~y;
    endtask

    task automatic run_op(logic [1:0] o, logic [31:0] x, logic [31:0] y, string tag);
        cur_tag = tag;
        pulse(o, x, y);
        while (m_busy) @(negedge clk);
    endtask

    task automatic idle(int n);
        cur_tag = "R9";
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset values observed by the per-cycle compare.
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 with R4: code 01 is unsigned multiply.
        run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 R4");
        idle(3);
        run_op(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R4");
        // R1 with R5: code 00 is signed multiply.
        run_op(2'b00, 32'hFFFF_FFFD, 32'd7, "R1 R5");
        run_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R5");
        run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
        // R1 with R6: code 11 is unsigned divide.
        run_op(2'b11, 32'd100, 32'd7, "R1 R6");
        run_op(2'b11, 32'hFFFF_FFFF, 32'h0001_0001, "R6");
        run_op(2'b11, 32'd3, 32'd10, "R6");
        // R1 with R7: code 10 is signed divide.
        run_op(2'b10, -32'sd100, 32'd7, "R1 R7");
        run_op(2'b10, 32'd100, -32'sd7, "R7");
        run_op(2'b10, -32'sd100, -32'sd7, "R7");
        run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, "R7");
        // R10: zero divisor, unsigned and signed.
        run_op(2'b11, 32'hDEAD_BEEF, 32'd0, "R10");
        run_op(2'b10, -32'sd5, 32'd0, "R10");
        idle(4);

        // R8: starts during busy, mid-operation and on the final cycle.
        cur_tag = "R8";
        pulse(2'b10, -32'sd1000, 32'd33);
        repeat (5) @(negedge clk);
        start = 1'b1; op = 2'b01; a = 32'hFFFF_0000; b = 32'h1234;
        @(negedge clk);
        start = 1'b0;
        while (m_left != 1) @(negedge clk);
        start = 1'b1; op = 2'b11; a = 32'd9; b = 32'd2;
        @(negedge clk);
        start = 1'b0;
        idle(3);

        // Mixed operands across all codes.
        for (int i = 0; i < 8; i++) begin
            run_op(2'(i), 32'h9E37_79B9 * (i + 1), 32'h7F4A_7C15 >> i, "R4 R5 R6 R7");
        end
        idle(3);

        // R11: reset while busy clears everything.
        pulse(2'b01, 32'd5, 32'd6);
        repeat (4) @(negedge clk);
        cur_tag = "R11";
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule